// File: doc/BRIEF.md
# Edge-Sensing Wake-Up Controller Group

This block serves eight asynchronous pin inputs as one group of a wake-up controller. Each pin passes through a synchronizer. An edge detector then compares the synchronized level with the level it held one clock earlier. Per pin, software selects which transition counts: rising, falling, or both. A qualifying transition sets a sticky status bit. Software clears that bit by writing a one to it.

The group drives a single wake-up request. That request is high whenever any pin has its status bit set while its enable bit is also set.

Software reaches four byte-wide registers through a simple register bus. Writes take effect on a clock edge, and reads are combinational from the address. A build-time parameter can remove the enable register. In that build the group is permanently enabled, the enable address reads as all ones, and writes to it are dropped.

Top module: `wuc_group`

## Requirements
- R1: With a pin's both-edge bit at 0 and its select bit at 0, only a low-to-high transition of that pin sets its status bit.
- R2: With a pin's both-edge bit at 0 and its select bit at 1, only a high-to-low transition sets its status bit.
- R3: With a pin's both-edge bit at 1, either transition sets its status bit, whatever the select bit holds.
- R4: Writing the status address clears each status bit written with 1 and leaves bits written with 0 unchanged.
- R5: When a qualifying edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: Status bits set regardless of enable. The wake-up output is the OR over pins of status AND enable.
- R7: The enable register reads back exactly what was last written, bit by bit.
- R8: With HAS_ENABLE = 0, the enable address reads 8'hFF, writes to it have no effect, and every pin with status set raises the wake-up output.
- R9: Changing the select or both-edge bits never sets a status bit by itself.
- R10: Reset leaves all four registers at 0 (rising mode, disabled, no status) and the wake-up output low.
- R11: A pin level change applied before clock edge k appears in the status register after edge k+2 and not earlier.
- R12: The address map is 0 = select, 1 = status, 2 = enable, 3 = both-edge. Bit i of each register belongs to pin i. Data written to the status address never sets a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| wake_o | output | 1 | Wake-up / interrupt request |

## Verification
The hardest case to reach is a clearing write that lands in exactly the cycle a new edge reaches the status register. That edge sits three clock edges behind the pin change, so the bench drives the pin change and then issues the clear two negative edges later, so that both arrive at the same rising edge.

A behavioural model tracks the pin history in a queue and predicts every register and the wake-up output each cycle. A long stretch of random pin activity and random writes then exercises mode changes against pins that hold steady. A second instance built without the enable register shares the same stimulus.

// File: rtl/wuc_pkg.sv
`timescale 1ns/1ps
package wuc_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEL  = 2'd0,
    REG_STAT = 2'd1,
    REG_EN   = 2'd2,
    REG_BOTH = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wuc_sync.sv
`timescale 1ns/1ps
module wuc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wuc_edge_sel.sv
`timescale 1ns/1ps
module wuc_edge_sel #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] lvl_i,
  input  logic [NUM_PINS-1:0] fall_sel_i,
  input  logic [NUM_PINS-1:0] both_i,
  output logic [NUM_PINS-1:0] hit_o
);
  logic [NUM_PINS-1:0] lvl_prev_q;

  // history only; mode bits never feed the comparison itself
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_prev_q <= '0;
    else         lvl_prev_q <= lvl_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall;
    assign rise = lvl_i[p] & ~lvl_prev_q[p];
    assign fall = ~lvl_i[p] & lvl_prev_q[p];
    always_comb begin
      if (both_i[p])          hit_o[p] = rise | fall;
      else if (fall_sel_i[p]) hit_o[p] = fall;
      else                    hit_o[p] = rise;
    end
  end
endmodule

// File: rtl/wuc_regfile.sv
`timescale 1ns/1ps
module wuc_regfile
  import wuc_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] hit_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic [NUM_PINS-1:0] fall_sel_o,
  output logic [NUM_PINS-1:0] both_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic [NUM_PINS-1:0] status_o
);
  reg_sel_e            sel;
  logic [NUM_PINS-1:0] fall_sel_q, both_q, status_q, clr;

  assign sel = reg_sel_e'(addr_i);
  assign clr = (we_i && sel == REG_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_sel_q <= '0;
      both_q     <= '0;
      status_q   <= '0;
    end else begin
      if (we_i && sel == REG_SEL)  fall_sel_q <= wdata_i;
      if (we_i && sel == REG_BOTH) both_q     <= wdata_i;
      // a fresh edge wins over a same-cycle clear
      status_q <= (status_q & ~clr) | hit_i;
    end
  end

  if (HAS_ENABLE) begin : g_en
    logic [NUM_PINS-1:0] en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   en_q <= '0;
      else if (we_i && sel == REG_EN) en_q <= wdata_i;
    end
    assign en_o = en_q;
  end else begin : g_no_en
    assign en_o = '1;
  end

  always_comb begin
    unique case (sel)
      REG_SEL:  rdata_o = fall_sel_q;
      REG_STAT: rdata_o = status_q;
      REG_EN:   rdata_o = en_o;
      REG_BOTH: rdata_o = both_q;
      default:  rdata_o = '0;
    endcase
  end

  assign fall_sel_o = fall_sel_q;
  assign both_o     = both_q;
  assign status_o   = status_q;
endmodule

// File: rtl/wuc_group.sv
`timescale 1ns/1ps
module wuc_group
  import wuc_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_ENABLE  = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] pin_sync, edge_hit, fall_sel, both_sel, en_eff, status_q;

  wuc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  wuc_edge_sel #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (pin_sync),
    .fall_sel_i(fall_sel),
    .both_i    (both_sel),
    .hit_o     (edge_hit)
  );

  wuc_regfile #(.NUM_PINS(NUM_PINS), .HAS_ENABLE(HAS_ENABLE)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .hit_i     (edge_hit),
    .rdata_o   (reg_rdata_o),
    .fall_sel_o(fall_sel),
    .both_o    (both_sel),
    .en_o      (en_eff),
    .status_o  (status_q)
  );

  assign wake_o = |(status_q & en_eff);
endmodule

// File: rtl/wuc_group_chk.sv
`timescale 1ns/1ps
module wuc_group_chk #(
  parameter int NUM_PINS   = 8,
  parameter bit HAS_ENABLE = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                we_i,
  input logic [1:0]          addr_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] hit_i,
  input logic [NUM_PINS-1:0] status_i,
  input logic [NUM_PINS-1:0] en_i,
  input logic                wake_i
);
  logic past_ok_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  a_r4_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && we_i && addr_i == 2'd1) |=> ((status_i & $past(wdata_i) & ~$past(hit_i)) == '0));

  a_r5_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && hit_i != '0) |=> ((status_i & $past(hit_i)) == $past(hit_i)));

  a_r9_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok_q |-> ((status_i & ~$past(status_i) & ~$past(hit_i)) == '0));

  a_r6_wake_needs_enabled_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |-> ((status_i & en_i) != '0));

  if (!HAS_ENABLE) begin : g_fixed
    a_r8_always_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i == '1);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r10_reset_clear: assert (status_i == '0 && !wake_i);
    end
  end
endmodule

bind wuc_group wuc_group_chk #(.NUM_PINS(NUM_PINS), .HAS_ENABLE(HAS_ENABLE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (reg_we_i),
  .addr_i  (reg_addr_i),
  .wdata_i (reg_wdata_i),
  .hit_i   (edge_hit),
  .status_i(status_q),
  .en_i    (en_eff),
  .wake_i  (wake_o)
);

// File: tb/wuc_group_tb.sv
`timescale 1ns/1ps
module wuc_group_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pins = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata_ne;
  logic       wake, wake_ne;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wuc_group u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .wake_o(wake));

  wuc_group #(.HAS_ENABLE(1'b0)) u_dut_noen (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata_ne), .wake_o(wake_ne));

  // behavioural reference
  logic [7:0] hist[$];
  logic [7:0] m_sel, m_stat, m_en, m_both;

  function automatic logic [7:0] m_read(input logic [1:0] a, input bit fixed);
    case (a)
      2'd0: return m_sel;
      2'd1: return m_stat;
      2'd2: return fixed ? 8'hFF : m_en;
      default: return m_both;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      hist = '{8'h00, 8'h00, 8'h00};
      m_sel = '0; m_stat = '0; m_en = '0; m_both = '0;
    end else begin
      logic [7:0] a, b, hit, clr;
      hist.push_back(pins);
      a = hist[hist.size()-4];
      b = hist[hist.size()-3];
      for (int i = 0; i < 8; i++) begin
        if (m_both[i])     hit[i] = a[i] ^ b[i];
        else if (m_sel[i]) hit[i] = a[i] & ~b[i];
        else               hit[i] = ~a[i] & b[i];
      end
      clr = (we && addr == 2'd1) ? wdata : 8'h00;
      m_stat = (m_stat & ~clr) | hit;
      if (we && addr == 2'd0) m_sel = wdata;
      if (we && addr == 2'd2) m_en = wdata;
      if (we && addr == 2'd3) m_both = wdata;
      if (hist.size() > 6) void'(hist.pop_front());
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R6 wake",          {7'd0, wake},    {7'd0, |(m_stat & m_en)});
      chk("R8 wake fixed-en", {7'd0, wake_ne}, {7'd0, |m_stat});
      chk("R12 rdata",        rdata,    m_read(addr, 1'b0));
      chk("R12 rdata fixed",  rdata_ne, m_read(addr, 1'b1));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic drive(input logic [7:0] p);
    @(negedge clk); pins = p;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd("R10 sel reset", 2'd0, 8'h00);
    rst_ni = 1'b1;
    rd("R10 sel", 2'd0, 8'h00);
    rd("R10 stat", 2'd1, 8'h00);
    rd("R10 en", 2'd2, 8'h00);
    rd("R10 both", 2'd3, 8'h00);
    chk("R10 wake", {7'd0, wake}, 8'h00);

    wr(2'd2, 8'hFF); rd("R7 en ff", 2'd2, 8'hFF);
    wr(2'd2, 8'h0F); rd("R7 en 0f", 2'd2, 8'h0F);

    drive(8'h01); rd("R1 rise sets", 2'd1, 8'h01);
    chk("R6 wake on enabled", {7'd0, wake}, 8'h01);
    wr(2'd1, 8'h01); rd("R4 w1c", 2'd1, 8'h00);
    drive(8'h00); rd("R1 fall ignored", 2'd1, 8'h00);

    wr(2'd0, 8'h02);
    drive(8'h02); rd("R2 rise ignored", 2'd1, 8'h00);
    drive(8'h00); rd("R2 fall sets", 2'd1, 8'h02);
    wr(2'd1, 8'h02);

    wr(2'd0, 8'h06); wr(2'd3, 8'h04);
    drive(8'h04); rd("R3 both rise", 2'd1, 8'h04);
    wr(2'd1, 8'h04);
    drive(8'h00); rd("R3 both fall", 2'd1, 8'h04);
    wr(2'd1, 8'h00); rd("R4 write zero keeps", 2'd1, 8'h04);
    wr(2'd1, 8'h04); rd("R4 cleared", 2'd1, 8'h00);

    drive(8'h10); rd("R6 status without enable", 2'd1, 8'h10);
    chk("R6 no wake while disabled", {7'd0, wake}, 8'h00);
    wr(2'd2, 8'hFF); #1;
    chk("R6 wake after enable", {7'd0, wake}, 8'h01);
    wr(2'd1, 8'h10); #1;
    chk("R6 wake drops on clear", {7'd0, wake}, 8'h00);

    // R5: clear collides with a new edge on a set bit
    drive(8'h30); rd("R5 preset", 2'd1, 8'h20);
    wr(2'd3, 8'h24);
    @(negedge clk); pins = 8'h10;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd1; wdata = 8'h20;
    @(negedge clk); we = 1'b0;
    rd("R5 edge beats clear", 2'd1, 8'h20);
    wr(2'd1, 8'h20); rd("R5 clear later", 2'd1, 8'h00);

    // R9: mode churn with steady pins
    drive(8'h18); wr(2'd1, 8'hFF);
    wr(2'd0, 8'h08); wr(2'd3, 8'h08); wr(2'd0, 8'h00); wr(2'd3, 8'h00); wr(2'd3, 8'hFF);
    repeat (4) @(negedge clk);
    rd("R9 no event from mode", 2'd1, 8'h00);

    wr(2'd2, 8'h00);
    @(negedge clk); addr = 2'd2; #1;
    chk("R8 fixed en reads ff", rdata_ne, 8'hFF);
    chk("R7 en write zero", rdata, 8'h00);

    // R11 latency
    @(negedge clk); addr = 2'd1; pins = 8'h58;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 not before k+2", rdata & 8'h40, 8'h00);
    @(posedge clk); #1;
    chk("R11 at k+2", rdata & 8'h40, 8'h40);

    // random phase, model compared every clock (R12)
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      pins = 8'($urandom);
      if (($urandom % 3) == 0) begin
        we = 1'b1; addr = 2'($urandom); wdata = 8'($urandom);
      end else begin
        we = 1'b0; addr = 2'($urandom);
      end
    end
    @(negedge clk); we = 1'b0;

    // R10 mid-run reset
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rd("R10 stat after reset", 2'd1, 8'h00);
    rd("R10 both after reset", 2'd3, 8'h00);
    chk("R10 wake after reset", {7'd0, wake}, 8'h00);
    pins = 8'h00;
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule